// File: doc/BRIEF.md
# Key-Restart Watchdog with Pre-Warning Timer

This block is a watchdog peripheral on a byte-wide register bus. It contains two 16-bit down-counters. The watchdog counter pulses a reset output when it runs out. The pre-warning counter raises an interrupt ahead of that. Both counters advance on a slow tick (nominally 1.024 kHz) that arrives from outside as a one-clock pulse. An optional divider can stretch the tick further. A period of N milliseconds is programmed as N*1024/1000 counts.

Software arms the watchdog by setting the run/lock bit in the configuration register. From then on the watchdog count registers are frozen. Software keeps the system alive by writing the key byte 0x5C to the key register, which reloads the watchdog counter. Further lock bits freeze the warning count registers and the divider setting. The only way to unlock is to write 0x00 to the configuration register, which also stops both counters. A stop bit in the control register halts the watchdog, but only when the stop-mode bit is also set.

Register addresses: 0 configuration, 1 and 2 watchdog count high and low byte, 3 and 4 warning count high and low byte, 5 control, 6 status, 7 tick divider, 8 key. Registers read back their stored values. The key register reads as zero.

Top module: `keyed_wdt`

## Requirements
- R1: After reset every register reads zero, irq_o is low and wdt_rst_o is low.
- R2: Writing 0x5C to address 8 while configuration bit 5 (key enable) is set reloads the watchdog counter from its count registers. Any other value, or any write while bit 5 is clear, leaves the countdown unchanged.
- R3: Writing configuration bit 3 (run) while it is clear loads both counters and starts counting. Bit 3 reads back as 1 and stays set until a write of 0x00 or a reset.
- R4: While configuration bit 3 is set, writes to addresses 1 and 2 are ignored and the old values read back.
- R5: When the watchdog counter, loaded with N (N>=1), has taken N counting ticks since its last load, wdt_rst_o is high for exactly one clock. The counter then reloads and keeps running.
- R6: Control bit 1 (stop) halts watchdog counting only while control bit 0 (stop mode) is also set. With bit 0 clear, bit 1 has no effect.
- R7: When the warning counter, loaded with M, has taken M ticks, status bit 0 is set and irq_o goes high. The counter reloads itself. Writing 1 to status bit 0 clears the bit and irq_o.
- R8: Writing 1 to control bit 2 reloads the warning counter from addresses 3 and 4. The bit reads back as 0.
- R9: While configuration bit 0 (warning count lock) is set, writes to addresses 3 and 4 are ignored.
- R10: Address 7 holds a divider D. The warning counter advances once every D+1 input ticks. The watchdog does the same when configuration bit 4 is set, and counts raw ticks when bit 4 is clear. While configuration bit 1 is set, writes to address 7 are ignored.
- R11: Writing 0x00 to the configuration register clears all its bits, stops both counters and unlocks every locked register. Any other write can set lock bits but cannot clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse at the slow tick rate |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Pre-warning interrupt, level, follows status bit 0 |
| wdt_rst_o | output | 1 | One-clock watchdog reset pulse |

## Verification
The hardest situation to reach is a key restart that lands one tick before expiry. Here a correct design must show no reset for a full new period, while a design that ignores the key would fire on the very next tick. The stimulus gets there by counting ticks from a known load: a start, or the previous reset pulse, which reloads the counter. Each key write, stop setting and divider change is then placed at an exact tick offset. The number of reset pulses seen after each step is compared with a count worked out by hand. The halt and the divider are checked the same way, by stepping exactly one tick past the point where an unhalted or undivided counter would already have fired.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_CFG  = 4'h0;
  localparam logic [AW-1:0] A_WHI  = 4'h1;
  localparam logic [AW-1:0] A_WLO  = 4'h2;
  localparam logic [AW-1:0] A_PHI  = 4'h3;
  localparam logic [AW-1:0] A_PLO  = 4'h4;
  localparam logic [AW-1:0] A_CTRL = 4'h5;
  localparam logic [AW-1:0] A_STAT = 4'h6;
  localparam logic [AW-1:0] A_DIV  = 4'h7;
  localparam logic [AW-1:0] A_KEY  = 4'h8;

  // configuration bits
  localparam int B_KEYEN = 5;
  localparam int B_SRC   = 4;
  localparam int B_RUN   = 3;
  localparam int B_DIVLK = 1;
  localparam int B_PLK   = 0;
  localparam int CFG_W   = 6;

  // control bits
  localparam int C_SMODE = 0;
  localparam int C_STOP  = 1;
  localparam int C_PRLD  = 2;
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int              DW      = 8,
  parameter logic [DW-1:0]   KEY_VAL = 8'h5C
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            warn_set_i,
  output logic [DW-1:0]   rdata_o,
  output logic            run_o,
  output logic            src_o,
  output logic            halt_o,
  output logic            start_o,
  output logic            key_hit_o,
  output logic            warn_rld_o,
  output logic            div_wr_o,
  output logic            stat_o,
  output logic [2*DW-1:0] wcnt_o,
  output logic [2*DW-1:0] pcnt_o,
  output logic [DW-1:0]   div_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [DW-1:0]    whi_q, wlo_q, phi_q, plo_q, div_q;
  logic [1:0]       ctrl_q;
  logic             stat_q;

  logic wr_cfg;
  assign wr_cfg     = we_i && (addr_i == A_CFG);
  assign start_o    = wr_cfg && (wdata_i != '0) && wdata_i[B_RUN] && !cfg_q[B_RUN];
  assign key_hit_o  = we_i && (addr_i == A_KEY) && (wdata_i == KEY_VAL) && cfg_q[B_KEYEN];
  assign warn_rld_o = we_i && (addr_i == A_CTRL) && wdata_i[C_PRLD];
  assign div_wr_o   = we_i && (addr_i == A_DIV) && !cfg_q[B_DIVLK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      if (wdata_i == '0) begin
        cfg_q <= '0;
      end else begin
        cfg_q[B_KEYEN] <= wdata_i[B_KEYEN];
        cfg_q[B_SRC]   <= wdata_i[B_SRC];
        // lock bits only accumulate
        cfg_q[B_RUN]   <= cfg_q[B_RUN]   | wdata_i[B_RUN];
        cfg_q[B_DIVLK] <= cfg_q[B_DIVLK] | wdata_i[B_DIVLK];
        cfg_q[B_PLK]   <= cfg_q[B_PLK]   | wdata_i[B_PLK];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      whi_q  <= '0;
      wlo_q  <= '0;
      phi_q  <= '0;
      plo_q  <= '0;
      div_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_WHI && !cfg_q[B_RUN]) whi_q <= wdata_i;
      if (addr_i == A_WLO && !cfg_q[B_RUN]) wlo_q <= wdata_i;
      if (addr_i == A_PHI && !cfg_q[B_PLK]) phi_q <= wdata_i;
      if (addr_i == A_PLO && !cfg_q[B_PLK]) plo_q <= wdata_i;
      if (div_wr_o) div_q <= wdata_i;
      if (addr_i == A_CTRL) ctrl_q <= wdata_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
    end else if (warn_set_i) begin
      stat_q <= 1'b1;
    end else if (we_i && addr_i == A_STAT && wdata_i[0]) begin
      stat_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = DW'(cfg_q);
      A_WHI:   rdata_o = whi_q;
      A_WLO:   rdata_o = wlo_q;
      A_PHI:   rdata_o = phi_q;
      A_PLO:   rdata_o = plo_q;
      A_CTRL:  rdata_o = DW'(ctrl_q);
      A_STAT:  rdata_o = DW'(stat_q);
      A_DIV:   rdata_o = div_q;
      default: rdata_o = '0;
    endcase
  end

  assign run_o  = cfg_q[B_RUN];
  assign src_o  = cfg_q[B_SRC];
  assign halt_o = ctrl_q[C_SMODE] & ctrl_q[C_STOP];
  assign stat_o = stat_q;
  assign wcnt_o = {whi_q, wlo_q};
  assign pcnt_o = {phi_q, plo_q};
  assign div_o  = div_q;
endmodule

// File: rtl/keyed_wdt_div.sv
module keyed_wdt_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_i)     cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = tick_i && (cnt_q == div_i);
endmodule

// File: rtl/keyed_wdt_down.sv
module keyed_wdt_down #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] val_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= val_i;
      end else if (dec_i) begin
        // a load of zero behaves as one
        if (cnt_q < W'(2)) begin
          cnt_q <= val_i;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] KEY_VAL = 8'h5C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wdt_rst_o
);
  localparam int CW = 2 * DW;

  logic          run, src, halt, start, key_hit, warn_rld, div_wr, stat;
  logic          ptick, wtick, warn_exp, wdt_exp;
  logic [CW-1:0] wcnt, pcnt;
  logic [DW-1:0] div;

  keyed_wdt_regs #(.DW(DW), .KEY_VAL(KEY_VAL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .warn_set_i (warn_exp),
    .rdata_o    (rdata_o),
    .run_o      (run),
    .src_o      (src),
    .halt_o     (halt),
    .start_o    (start),
    .key_hit_o  (key_hit),
    .warn_rld_o (warn_rld),
    .div_wr_o   (div_wr),
    .stat_o     (stat),
    .wcnt_o     (wcnt),
    .pcnt_o     (pcnt),
    .div_o      (div)
  );

  keyed_wdt_div #(.W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (div_wr | start),
    .div_i  (div),
    .tick_o (ptick)
  );

  assign wtick = src ? ptick : tick_i;

  keyed_wdt_down #(.W(CW)) u_wdt_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start | key_hit),
    .dec_i  (run & wtick & ~halt),
    .val_i  (wcnt),
    .exp_o  (wdt_exp)
  );

  keyed_wdt_down #(.W(CW)) u_warn_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start | warn_rld),
    .dec_i  (run & ptick),
    .val_i  (pcnt),
    .exp_o  (warn_exp)
  );

  assign irq_o     = stat;
  assign wdt_rst_o = wdt_exp;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [3:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          run_i,
  input logic          halt_i,
  input logic          irq_i,
  input logic          wrst_i,
  input logic [DW-1:0] whi_i
);
  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrst_i |=> !wrst_i);

  // R5
  rst_when_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrst_i |-> $past(run_i));

  // R3
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(we_i && addr_i == 4'h0 && wdata_i == '0)) |=> run_i);

  // R4
  cnt_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && we_i && addr_i == 4'h1) |=> $stable(whi_i));

  // R6
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !wrst_i);

  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !(we_i && addr_i == 4'h6 && wdata_i[0])) |=> irq_i);
endmodule

bind keyed_wdt keyed_wdt_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .run_i   (run),
  .halt_i  (halt),
  .irq_i   (irq_o),
  .wrst_i  (wdt_rst_o),
  .whi_i   (wcnt[2*DW-1:DW])
);

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wrst;
  int n_chk = 0, n_bad = 0, rst_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
  );

  always @(posedge clk) if (wrst) rst_cnt <= rst_cnt + 1;

  // {kind, req, addr, data, exp}; kind 1 write, 2 read, 3 ticks, 4 reset pulses, 5 irq
  localparam int NV = 64;
  localparam logic [27:0] VEC [NV] = '{
    28'h1310000, 28'h1320400, 28'h1730000, 28'h1740200,   // R3 R7 setup
    28'h1303800, 28'h2300038,                             // R3 start
    28'h1420900, 28'h2420004,                             // R4 locked count
    28'h3700100, 28'h5700000, 28'h3700100, 28'h5700001,   // R7 warning
    28'h4500000, 28'h2760001, 28'h1760100, 28'h5700000,   // R5 R7 clear
    28'h1281200, 28'h3200200, 28'h4200001,                // R2 wrong key
    28'h3200300, 28'h1285C00, 28'h3200300, 28'h4200001,   // R2 good key
    28'h3500100, 28'h4500002,                             // R5
    28'h1650200, 28'h3600400, 28'h4600003,                // R6 stop w/o mode
    28'h1650300, 28'h2650003, 28'h3600800, 28'h4600003,   // R6 halted
    28'h1650000, 28'h3600300, 28'h4600003, 28'h3600100, 28'h4600004,
    28'h1840500, 28'h1850400, 28'h1860100, 28'h5800000,   // R8 reload
    28'h3800400, 28'h5800000, 28'h3800100, 28'h5800001,
    28'h1903900, 28'h2900039, 28'h1940700, 28'h2940005,   // R9
    28'h1B00000, 28'h2B00000, 28'h1B60100, 28'h3B00A00,   // R11
    28'h4B00005, 28'h5B00000, 28'h1B20200, 28'h2B20002,
    28'h1A70100, 28'h2A70001, 28'h1A03A00, 28'h3A00300,   // R10 divider
    28'h4A00005, 28'h3A00100, 28'h4A00006
  };

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, all requirements unfinished actual=hang expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [3:0] kind, rq, a;
    logic [7:0] d, e;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, r); chk("R1 cfg", r, 0);
    rd(4'h2, r); chk("R1 wdt lo", r, 0);
    rd(4'h6, r); chk("R1 status", r, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt_rst", wrst, 0);

    for (int i = 0; i < NV; i++) begin
      {kind, rq, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (kind)
        4'h1: wr(a, d);
        4'h2: begin rd(a, r); chk(tag, r, e); end
        4'h3: tk(int'(d));
        4'h4: begin @(negedge clk); chk(tag, rst_cnt, e); end
        4'h5: begin @(negedge clk); chk(tag, irq, e); end
        default: ;
      endcase
    end

    // R10 divider locked by cfg bit 1
    wr(4'h7, 8'h00); rd(4'h7, r); chk("R10 div locked", r, 1);
    // R10 raw tick source with bit 4 clear
    wr(4'h0, 8'h00); wr(4'h0, 8'h2A);
    tk(1); @(negedge clk); chk("R10 raw src t1", rst_cnt, 6);
    tk(1); @(negedge clk); chk("R10 raw src t2", rst_cnt, 7);
    // R2 key ignored while key enable clear
    wr(4'h0, 8'h00); wr(4'h0, 8'h08);
    tk(1); wr(4'h8, 8'h5C); tk(1);
    @(negedge clk); chk("R2 key disabled", rst_cnt, 8);
    // R1 reset while running
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'h0, r); chk("R1 cfg after rst", r, 0);
    rd(4'h2, r); chk("R1 wdt lo after rst", r, 0);
    rd(4'h7, r); chk("R1 div after rst", r, 0);
    rd(4'h6, r); chk("R1 status after rst", r, 0);
    chk("R1 irq after rst", irq, 0);
    tk(5); @(negedge clk); chk("R1 stopped after rst", rst_cnt, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule